// File: doc/BRIEF.md
# Shift-Clock Timer with Start/Stop Framing

This block produces the shift clock for a serial shifter and the strobes that frame its words. A single counter register is loaded from a compare value. In wide mode it is one 16-bit divider. In the two split modes it is two 8-bit halves. In baud/bit mode the low half divides the clock for each shift-clock half period, and the high half counts edges to close each word. In PWM mode the two halves time the high and low phases of the output.

Framing is controlled by a start-bit enable and a 2-bit stop-bit setting. The block tells the shifter when to drive a start bit, when to drive a stop bit, and when a word is complete. An enable trigger starts the timer. A reset trigger reloads the counter. A disable trigger stops the timer, either at once or after a closing stop bit that ends on the next rising shift-clock edge. Every pin is a plain control or status level. There is no streamed data and so no valid/ready handshake.

Top module: `shclk_timer`

## Requirements
- R1: While reset is held, and on the first cycle after it, `busy`, `tmr_out`, `start_bit`, `stop_bit` and `word_done` are all 0.
- R2: With `busy` at 0, a cycle with `en_trig` high makes `busy` 1 and `tmr_out` 0 on the next cycle, with the counter loaded from the compare value. While busy, `rst_trig` reloads the full counter from the compare value and leaves `tmr_out` unchanged.
- R3: Mode 00 (wide): `tmr_out` toggles each time the 16-bit count passes zero, so its period is (C+1)*2 clocks. `word_done` pulses for one cycle on every falling edge of `tmr_out`.
- R4: Mode 01 (baud/bit): `tmr_out` toggles every L+1 clocks, where L = C[7:0]. `word_done` pulses on the toggle where both halves are zero, which is every H+1 toggles (H = C[15:8]), that is (H+1)/2 shift-clock periods per word.
- R5: Mode 10 (PWM): after enable, `tmr_out` is low for H+1 clocks and then high for L+1 clocks, repeating. `word_done` pulses as each low phase ends.
- R6: With `start_en` = 1 at enable, `start_bit` is 1 from the first busy cycle until the first rising edge of `tmr_out`. On that edge the whole counter reloads from the compare value and no `word_done` occurs.
- R7: Stop setting 01, or 11 between words: a `word_done` raises `stop_bit` in the same cycle, and `stop_bit` holds until the next rising edge of `tmr_out`.
- R8: Stop setting 10: `dis_trig` raises `stop_bit` on the next cycle while the timer keeps running. On the next rising edge, `busy`, `tmr_out` and `stop_bit` all drop to 0 together.
- R9: Stop setting 11: a disable produces a single stop bit that ends on the first rising edge after `dis_trig`, even if a word-end stop bit was already in progress.
- R10: `en_trig` has no effect while `busy` is 1, including during a closing stop bit.
- R11: Stop setting 00 or 01: `dis_trig` makes `busy`, `tmr_out`, `start_bit` and `stop_bit` 0 on the next cycle.
- R12: Bits 31..16 of `cmp_cfg` have no effect on any output.
- R13: Mode 11 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_cfg | input | 32 | Compare value; only bits 15..0 are used |
| mode | input | 2 | 00 wide, 01 baud/bit, 10 PWM, 11 same as 00 |
| stop_cfg | input | 2 | Bit 0: stop bit between words; bit 1: stop bit on disable |
| start_en | input | 1 | Insert a start bit after enable |
| en_trig | input | 1 | Enable trigger (used only while idle) |
| dis_trig | input | 1 | Disable trigger |
| rst_trig | input | 1 | Counter reload trigger |
| tmr_out | output | 1 | Timer output / shift clock |
| start_bit | output | 1 | Shifter should drive the start bit |
| stop_bit | output | 1 | Shifter should drive the stop bit |
| word_done | output | 1 | One-cycle pulse at the end of each word |
| busy | output | 1 | Timer enabled |

## Verification
Every output is a register, so a trigger or counter event in one cycle appears on the pins exactly one clock later. `word_done` and `stop_bit` rise in the same cycle as the `tmr_out` edge that caused them. A closing stop bit drops on the cycle where `tmr_out` would have risen. The bench steps a behavioural model on each rising edge using the inputs seen there, and compares all five outputs with it at the following falling edge. Each expected value is therefore checked in the exact cycle it is due. All four stop settings, the start bit, the triggers, the reserved mode and the ignored upper compare bits are all exercised.

// File: rtl/shclk_pkg.sv
package shclk_pkg;
  typedef enum logic [1:0] {
    TM_WIDE = 2'b00,
    TM_BAUD = 2'b01,
    TM_PWM  = 2'b10,
    TM_RSVD = 2'b11
  } tmode_e;
endpackage

// File: rtl/shclk_count.sv
module shclk_count
  import shclk_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CW = 2 * HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmode_e        mode,
  input  logic [CW-1:0] cmp,
  input  logic          load,
  input  logic          clr,
  input  logic          full_rl,
  input  logic          adv,
  output logic          tout,
  output logic          tog,
  output logic          ev_raw
);
  logic [CW-1:0]     cnt, nxt;
  logic [HALF_W-1:0] lo, hi, c_lo, c_hi;
  logic              lo_z, hi_z;

  assign lo   = cnt[HALF_W-1:0];
  assign hi   = cnt[CW-1:HALF_W];
  assign c_lo = cmp[HALF_W-1:0];
  assign c_hi = cmp[CW-1:HALF_W];
  assign lo_z = (lo == '0);
  assign hi_z = (hi == '0);

  always_comb begin
    case (mode)
      TM_BAUD: begin
        tog    = lo_z;
        ev_raw = lo_z && hi_z;
        nxt    = {(lo_z ? (hi_z ? c_hi : HALF_W'(hi - 1'b1)) : hi),
                  (lo_z ? c_lo : HALF_W'(lo - 1'b1))};
      end
      TM_PWM: begin
        if (tout) begin
          tog    = lo_z;
          ev_raw = 1'b0;
          nxt    = {hi, (lo_z ? c_lo : HALF_W'(lo - 1'b1))};
        end else begin
          tog    = hi_z;
          ev_raw = hi_z;
          nxt    = {(hi_z ? c_hi : HALF_W'(hi - 1'b1)), lo};
        end
      end
      default: begin
        tog    = (cnt == '0);
        ev_raw = tog && tout;
        nxt    = tog ? cmp : CW'(cnt - 1'b1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tout <= 1'b0;
    end else begin
      if (clr) tout <= 1'b0;
      if (load) begin
        cnt <= cmp;
      end else if (full_rl) begin
        cnt  <= cmp;
        tout <= 1'b1;
      end else if (adv) begin
        cnt  <= nxt;
        tout <= tout ^ tog;
      end
    end
  end

  // PWM low phase must last exactly one hi-half count down: the output never rises while hi is nonzero
  assert_pwm_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_PWM && adv && !load && !full_rl && !tout && !hi_z) |=> !tout);
endmodule

// File: rtl/shclk_ctrl.sv
module shclk_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_trig,
  input  logic       dis_trig,
  input  logic       rst_trig,
  input  logic       start_en,
  input  logic [1:0] stop_cfg,
  input  logic       tout,
  input  logic       tog,
  input  logic       ev_raw,
  output logic       busy,
  output logic       start_bit,
  output logic       stop_bit,
  output logic       word_done,
  output logic       load,
  output logic       clr,
  output logic       full_rl,
  output logic       adv
);
  logic active, in_start, stop_cmp, stop_dis;
  logic pre, rise_p, term_stop, term_now, term, go, ev, rise_adv, arm_dis;

  assign go        = !active && en_trig;
  assign pre       = active && !rst_trig;
  assign rise_p    = pre && tog && !tout;
  assign term_stop = stop_dis && rise_p;
  assign term_now  = active && !stop_dis && dis_trig && !stop_cfg[1];
  assign term      = term_stop || term_now;
  assign adv       = pre && !term;
  assign full_rl   = adv && in_start && tog && !tout;
  assign rise_adv  = adv && tog && !tout;
  assign ev        = adv && ev_raw && !full_rl;
  assign load      = go || (active && rst_trig && !term);
  assign clr       = go || term;
  assign arm_dis   = active && !stop_dis && dis_trig && stop_cfg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      in_start  <= 1'b0;
      stop_cmp  <= 1'b0;
      stop_dis  <= 1'b0;
      word_done <= 1'b0;
    end else if (go) begin
      active    <= 1'b1;
      in_start  <= start_en;
      stop_cmp  <= 1'b0;
      stop_dis  <= 1'b0;
      word_done <= 1'b0;
    end else if (term) begin
      active    <= 1'b0;
      in_start  <= 1'b0;
      stop_cmp  <= 1'b0;
      stop_dis  <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= ev;
      if (full_rl) in_start <= 1'b0;
      if (ev && stop_cfg[0]) stop_cmp <= 1'b1;
      else if (rise_adv)     stop_cmp <= 1'b0;
      if (arm_dis) stop_dis <= 1'b1;
    end
  end

  assign busy      = active;
  assign start_bit = in_start;
  assign stop_bit  = stop_cmp || stop_dis;

  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && en_trig) |=> (active && !tout));
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_start |-> active);
  assert_stop_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_dis) |-> (!active && !tout));
  assert_imm_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !stop_dis && dis_trig && !stop_cfg[1]) |=> (!active && !tout && !stop_bit));
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!tout && !word_done));
endmodule

// File: rtl/shclk_timer.sv
module shclk_timer
  import shclk_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int CFG_W  = 32,
  localparam int CW = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cmp_cfg,
  input  logic [1:0]       mode,
  input  logic [1:0]       stop_cfg,
  input  logic             start_en,
  input  logic             en_trig,
  input  logic             dis_trig,
  input  logic             rst_trig,
  output logic             tmr_out,
  output logic             start_bit,
  output logic             stop_bit,
  output logic             word_done,
  output logic             busy
);
  logic tog, ev_raw, load, clr, full_rl, adv;

  generate
    if (CFG_W > CW) begin : g_pad
      logic unused_upper;
      assign unused_upper = ^cmp_cfg[CFG_W-1:CW];
    end
  endgenerate

  shclk_count #(.HALF_W(HALF_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (tmode_e'(mode)),
    .cmp     (cmp_cfg[CW-1:0]),
    .load    (load),
    .clr     (clr),
    .full_rl (full_rl),
    .adv     (adv),
    .tout    (tmr_out),
    .tog     (tog),
    .ev_raw  (ev_raw)
  );

  shclk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_trig   (en_trig),
    .dis_trig  (dis_trig),
    .rst_trig  (rst_trig),
    .start_en  (start_en),
    .stop_cfg  (stop_cfg),
    .tout      (tmr_out),
    .tog       (tog),
    .ev_raw    (ev_raw),
    .busy      (busy),
    .start_bit (start_bit),
    .stop_bit  (stop_bit),
    .word_done (word_done),
    .load      (load),
    .clr       (clr),
    .full_rl   (full_rl),
    .adv       (adv)
  );
endmodule

// File: tb/tb_shclk_timer.sv
`timescale 1ns/1ps
module tb_shclk_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cmp_cfg = '0;
  logic [1:0]  mode = 2'b00, stop_cfg = 2'b00;
  logic        start_en = 1'b0, en_trig = 1'b0, dis_trig = 1'b0, rst_trig = 1'b0;
  logic        tmr_out, start_bit, stop_bit, word_done, busy;

  int n_run = 0, n_fail = 0;
  string tg = "R1";
  bit cmp_on = 1'b0;

  // reference state
  int  m_cnt = 0;
  bit  m_act = 0, m_out = 0, m_st = 0, m_sc = 0, m_sd = 0, m_wd = 0;

  always #2.5 clk = ~clk;

  shclk_timer dut (
    .clk(clk), .rst_n(rst_n), .cmp_cfg(cmp_cfg), .mode(mode), .stop_cfg(stop_cfg),
    .start_en(start_en), .en_trig(en_trig), .dis_trig(dis_trig), .rst_trig(rst_trig),
    .tmr_out(tmr_out), .start_bit(start_bit), .stop_bit(stop_bit),
    .word_done(word_done), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_out = 0; m_st = 0; m_sc = 0; m_sd = 0; m_wd = 0; m_cnt = 0;
    end else begin
      int c, lo, hi, clo, chi, ncnt;
      bit tgl, ev, rise, setd;
      c = int'(cmp_cfg[15:0]); clo = c % 256; chi = c / 256;
      lo = m_cnt % 256; hi = m_cnt / 256;
      m_wd = 0;
      if (!m_act) begin
        if (en_trig) begin
          m_act = 1; m_cnt = c; m_out = 0; m_st = start_en; m_sc = 0; m_sd = 0;
        end
      end else if (!m_sd && dis_trig && !stop_cfg[1]) begin
        m_act = 0; m_out = 0; m_st = 0; m_sc = 0; m_sd = 0;
      end else begin
        setd = !m_sd && dis_trig && stop_cfg[1];
        if (rst_trig) begin
          m_cnt = c;
          if (setd) m_sd = 1;
        end else begin
          if (mode == 2'b01) begin
            tgl = (lo == 0); ev = (lo == 0) && (hi == 0);
            ncnt = (lo == 0) ? (((hi == 0) ? chi : hi - 1) * 256 + clo) : (hi * 256 + lo - 1);
          end else if (mode == 2'b10) begin
            if (m_out) begin
              tgl = (lo == 0); ev = 0;
              ncnt = hi * 256 + ((lo == 0) ? clo : lo - 1);
            end else begin
              tgl = (hi == 0); ev = (hi == 0);
              ncnt = ((hi == 0) ? chi : hi - 1) * 256 + lo;
            end
          end else begin
            tgl = (m_cnt == 0); ev = tgl && m_out;
            ncnt = tgl ? c : m_cnt - 1;
          end
          rise = tgl && !m_out;
          if (m_sd && rise) begin
            m_act = 0; m_out = 0; m_st = 0; m_sc = 0; m_sd = 0;
          end else begin
            if (m_st && rise) begin
              m_cnt = c; m_out = 1; m_st = 0; m_sc = 0;
            end else begin
              m_cnt = ncnt; m_out = m_out ^ tgl; m_wd = ev;
              if (ev && stop_cfg[0]) m_sc = 1;
              else if (rise) m_sc = 0;
            end
            if (setd) m_sd = 1;
          end
        end
      end
    end
  end

  function automatic string stop_tag();
    case (stop_cfg)
      2'b01: return "R7";
      2'b10: return "R8";
      2'b11: return "R9";
      default: return "R11";
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) if (cmp_on) begin
    chk(tg, "tmr_out", tmr_out, m_out);
    chk(tg, "word_done", word_done, m_wd);
    chk(tg, "busy", busy, m_act);
    chk("R6", "start_bit", start_bit, m_st);
    chk(stop_tag(), "stop_bit", stop_bit, m_sc | m_sd);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_en();
    en_trig = 1'b1; cyc(1); en_trig = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_trig = 1'b1; cyc(1); dis_trig = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 2000) begin cyc(1); k++; end
    chk(req, "returned to idle", busy, 0);
  endtask

  task automatic run(input string t, input logic [31:0] c, input logic [1:0] md,
                     input logic [1:0] sc, input bit se, input int len);
    tg = t; cmp_cfg = c; mode = md; stop_cfg = sc; start_en = se;
    pulse_en();
    chk("R2", "busy after enable", busy, 1);
    chk("R2", "tmr_out after enable", tmr_out, 0);
    cyc(len);
    pulse_dis();
    wait_idle(stop_tag());
    cyc(3);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "tmr_out in reset", tmr_out, 0);
    chk("R1", "stop_bit in reset", stop_bit, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "word_done after reset", word_done, 0);
    chk("R1", "start_bit after reset", start_bit, 0);
    cmp_on = 1'b1;

    run("R3", 32'h0000_0003, 2'b00, 2'b00, 1'b0, 40);
    run("R3", 32'h0000_0000, 2'b00, 2'b01, 1'b0, 13);
    run("R4", 32'h0000_0301, 2'b01, 2'b01, 1'b1, 61);
    run("R4", 32'h0000_0702, 2'b01, 2'b10, 1'b0, 47);
    run("R5", 32'h0000_0402, 2'b10, 2'b11, 1'b0, 44);
    run("R5", 32'h0000_0100, 2'b10, 2'b11, 1'b1, 23);
    run("R9", 32'h0000_0100, 2'b01, 2'b11, 1'b0, 17);
    run("R12", 32'hABCD_0005, 2'b00, 2'b00, 1'b0, 37);
    run("R13", 32'h0000_0002, 2'b11, 2'b10, 1'b1, 29);

    // R10: enable ignored while busy and during closing stop bit; R2: reload trigger
    tg = "R10"; cmp_cfg = 32'h0000_0004; mode = 2'b00; stop_cfg = 2'b10; start_en = 1'b0;
    pulse_en();
    cyc(7);
    pulse_en();
    cyc(5);
    tg = "R2"; rst_trig = 1'b1; cyc(1); rst_trig = 1'b0;
    cyc(9);
    tg = "R10";
    dis_trig = 1'b1; cyc(1); dis_trig = 1'b0; en_trig = 1'b1;
    cyc(2); en_trig = 1'b0;
    chk("R8", "stop_bit while closing", stop_bit, 1);
    wait_idle("R10");
    cyc(4);

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule